// File: doc/BRIEF.md
# Serial Control Port, Write-Only SPI Mode

This block receives control writes over a write-only serial control port. Its chip-select pin is shared with the address strap of a two-wire control interface. After reset the port stays in two-wire mode. It switches to SPI mode the first time the shared pin is seen going from high to low, and it stays in SPI mode until the next reset. The `spi_mode_o` output tells the two-wire logic to stand down.

In SPI mode, each frame opens when chip select goes low. The first byte must be the fixed chip address 0x98; any other value makes the port ignore the rest of the frame. The second byte is loaded into an 8-bit pointer. Bits 6:0 of the pointer give the register address, and bit 7 is an auto-increment flag. Every complete byte after that is written to the register file at the pointed address.

All pins are sampled by the system clock through synchronizers. Serial data is taken on rising edges of the serial clock, most significant bit first.

Top module: `spi_ctrl_port`

## Requirements
- R1: While reset is asserted and right after it, `spi_mode_o` and `wr_en_o` are 0.
- R2: The first high-to-low transition of `cs_i` seen after reset sets `spi_mode_o` to 1. A `cs_i` held low through reset does not set it, and a low-to-high transition does not set it either.
- R3: Once `spi_mode_o` is 1, it stays 1 until reset, whatever `cs_i` does.
- R4: Data bits are taken from `cdin_i` on rising edges of `cclk_i` while `cs_i` is low, MSB first. Edges of `cclk_i` while `cs_i` is high are ignored.
- R5: If the first byte of a frame is not 0x98, that frame produces no write, however many bytes follow it.
- R6: The second byte of a frame is loaded into the pointer. Bits 6:0 give the address of the first write, and bit 7 is the auto-increment flag.
- R7: Each complete data byte produces exactly one write: `wr_en_o` is high for a single cycle, with `wr_addr_o` set to the pointer address and `wr_data_o` set to the byte.
- R8: If pointer bit 7 is 1, the address advances by one after each data byte and wraps from 0x7F to 0x00. If bit 7 is 0, every data byte of the frame goes to the same address.
- R9: When `cs_i` goes high in the middle of a byte, the partial byte is dropped with no write, and the next frame again starts with the chip address byte.
- R10: No write is produced while `spi_mode_o` is 0, even if `cclk_i` and `cdin_i` carry a valid frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Shared chip select / address strap pin |
| cclk_i | input | 1 | Serial control clock |
| cdin_i | input | 1 | Serial control data |
| spi_mode_o | output | 1 | 1 once SPI mode has been selected |
| wr_en_o | output | 1 | Register-file write strobe, one cycle |
| wr_addr_o | output | 7 | Register-file write address |
| wr_data_o | output | 8 | Register-file write data |

## Verification
The hardest situation to reach is a pin that is already low when reset ends. The synchronizer reset value must not turn that level into a false falling edge, and a complete, valid frame clocked in at that point must still produce no write. The bench starts with `cs_i` low during reset and clocks a full frame with no chip-select edge. It then raises the pin and lowers it again, checking that SPI mode is selected only on that fall. Random frames then mix wrong chip addresses, short frames, truncated bytes and pointers near the wrap point.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  typedef enum logic [1:0] {
    FR_CHIP = 2'd0,
    FR_PTR  = 2'd1,
    FR_DATA = 2'd2,
    FR_SKIP = 2'd3
  } frame_st_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] FALL_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] edge_o
);
  localparam int CNT_W = $clog2(STAGES + 2);
  localparam logic [CNT_W-1:0] ARM_AT = CNT_W'(STAGES + 1);

  logic [CNT_W-1:0] arm_cnt_q;
  logic             armed;

  // edges are only trusted once the chain holds real samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                arm_cnt_q <= '0;
    else if (arm_cnt_q != ARM_AT) arm_cnt_q <= arm_cnt_q + 1'b1;
  end
  assign armed = (arm_cnt_q == ARM_AT);

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[g] = chain_q[STAGES-1];

    if (FALL_MASK[g]) begin : g_fall
      assign edge_o[g] = armed & prev_q & ~chain_q[STAGES-1];
    end else begin : g_rise
      assign edge_o[g] = armed & ~prev_q & chain_q[STAGES-1];
    end
  end
endmodule

// File: rtl/spi_mode_latch.sv
module spi_mode_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_fall_i,
  output logic mode_o
);
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= 1'b0;
    else if (cs_fall_i) mode_q <= 1'b1;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_ctrl_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 7,
  parameter logic [BYTE_W-1:0] CHIP_ID = 8'h98
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              cs_lvl_i,
  input  logic              cclk_rise_i,
  input  logic              cdin_lvl_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int BIT_W   = $clog2(BYTE_W);
  localparam int INC_BIT = BYTE_W - 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  frame_st_e         st_q;
  logic [BYTE_W-1:0] shift_q, shift_nx;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] ptr_q;
  logic              active, take_bit, byte_done;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;

  assign active    = mode_i & ~cs_lvl_i;
  assign take_bit  = active & cclk_rise_i;
  assign byte_done = take_bit & (bit_cnt_q == LAST_BIT);
  assign shift_nx  = {shift_q[BYTE_W-2:0], cdin_lvl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= FR_CHIP;
      shift_q   <= '0;
      bit_cnt_q <= '0;
    end else if (!active) begin
      st_q      <= FR_CHIP;
      bit_cnt_q <= '0;
    end else if (take_bit) begin
      shift_q   <= shift_nx;
      bit_cnt_q <= byte_done ? '0 : bit_cnt_q + 1'b1;
      if (byte_done) begin
        unique case (st_q)
          FR_CHIP: st_q <= (shift_nx == CHIP_ID) ? FR_PTR : FR_SKIP;
          FR_PTR:  st_q <= FR_DATA;
          FR_DATA: st_q <= FR_DATA;
          FR_SKIP: st_q <= FR_SKIP;
          default: st_q <= FR_SKIP;
        endcase
      end
    end
  end

  // pointer survives chip-select high; only the next pointer byte replaces it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (byte_done && st_q == FR_PTR) begin
      ptr_q <= shift_nx;
    end else if (byte_done && st_q == FR_DATA && ptr_q[INC_BIT]) begin
      ptr_q[ADDR_W-1:0] <= ptr_q[ADDR_W-1:0] + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= byte_done && (st_q == FR_DATA);
      if (byte_done && st_q == FR_DATA) begin
        wr_addr_q <= ptr_q[ADDR_W-1:0];
        wr_data_q <= shift_nx;
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  logic unused_ptr;
  assign unused_ptr = ^ptr_q;
endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 7,
  parameter logic [BYTE_W-1:0] CHIP_ID = 8'h98
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              cclk_i,
  input  logic              cdin_i,
  output logic              spi_mode_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int PIN_N = 3;
  localparam int P_CS = 0, P_CCLK = 1, P_CDIN = 2;
  localparam logic [PIN_N-1:0] FALL_PINS = PIN_N'(1 << P_CS);

  logic [PIN_N-1:0] pin_lvl, pin_edge;
  logic             mode;

  spi_pin_sync #(
    .WIDTH    (PIN_N),
    .STAGES   (SYNC_STAGES),
    .FALL_MASK(FALL_PINS)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i ({cdin_i, cclk_i, cs_i}),
    .lvl_o (pin_lvl),
    .edge_o(pin_edge)
  );

  spi_mode_latch u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_fall_i(pin_edge[P_CS]),
    .mode_o   (mode)
  );

  spi_frame_rx #(
    .BYTE_W (BYTE_W),
    .ADDR_W (ADDR_W),
    .CHIP_ID(CHIP_ID)
  ) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .cs_lvl_i   (pin_lvl[P_CS]),
    .cclk_rise_i(pin_edge[P_CCLK]),
    .cdin_lvl_i (pin_lvl[P_CDIN]),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  assign spi_mode_o = mode;

  logic unused_pins;
  assign unused_pins = pin_lvl[P_CCLK] ^ pin_edge[P_CDIN];
endmodule

// File: rtl/spi_ctrl_port_chk.sv
module spi_ctrl_port_chk #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spi_mode_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [BYTE_W-1:0] wr_data_o
);
  // R3
  mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_mode_o |=> spi_mode_o);

  // R10
  wr_needs_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> spi_mode_o);

  // R7
  wr_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  // R7
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> ($stable(wr_addr_o) && $stable(wr_data_o)));
endmodule

bind spi_ctrl_port spi_ctrl_port_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .spi_mode_o(spi_mode_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o)
);

// File: tb/spi_ctrl_port_test.sv
module spi_ctrl_port_test;
  localparam int CLK_NS = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 1'b0;
  logic       cclk_i = 1'b0;
  logic       cdin_i = 1'b0;
  logic       spi_mode_o, wr_en_o;
  logic [6:0] wr_addr_o;
  logic [7:0] wr_data_o;

  always #(CLK_NS / 2) clk = ~clk;

  spi_ctrl_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs_i), .cclk_i(cclk_i), .cdin_i(cdin_i),
    .spi_mode_o(spi_mode_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  int errors = 0, checks = 0;
  int exp_wr = 0, exp_rd = 0, seen = 0;
  bit done = 0;
  logic [6:0] exp_a[0:1023];
  logic [7:0] exp_d[0:1023];
  logic [7:0] fb[0:15];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && wr_en_o) begin
      seen++;
      if (exp_rd >= exp_wr) begin
        chk(1'b0, "R5/R9/R10", "unexpected write addr", int'(wr_addr_o), -1);
      end else begin
        chk(wr_addr_o == exp_a[exp_rd], "R6/R8", "write address", int'(wr_addr_o), int'(exp_a[exp_rd]));
        chk(wr_data_o == exp_d[exp_rd], "R7", "write data", int'(wr_data_o), int'(exp_d[exp_rd]));
        exp_rd++;
      end
    end
  end

  // bench model of the frame rules
  function automatic void expect_frame(input int n);
    logic [7:0] ptr;
    if (n < 2 || fb[0] != 8'h98) return;
    ptr = fb[1];
    for (int i = 2; i < n; i++) begin
      exp_a[exp_wr] = ptr[6:0];
      exp_d[exp_wr] = fb[i];
      exp_wr++;
      if (ptr[7]) ptr[6:0] = ptr[6:0] + 7'd1;
    end
  endfunction

  task automatic bit_out(input logic b);
    @(negedge clk);
    cclk_i = 1'b0;
    cdin_i = b;
    repeat (3) @(negedge clk);
    cclk_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (4) @(negedge clk);
    cclk_i = 1'b0;
    cs_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input int partial);
    expect_frame(n);
    cs_low();
    for (int i = 0; i < n; i++) byte_out(fb[i]);
    for (int j = 0; j < partial; j++) bit_out(logic'($urandom % 2));
    cs_high();
    chk(exp_rd == exp_wr, "R7", "writes still pending", exp_wr - exp_rd, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired: actual=%0d expected=%0d", exp_rd, exp_wr);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(spi_mode_o == 1'b0 && wr_en_o == 1'b0, "R1", "outputs in reset", {spi_mode_o, wr_en_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_mode_o == 1'b0, "R1", "mode after reset", spi_mode_o, 0);

    // R2 strap held low through reset: no false fall
    repeat (20) @(negedge clk);
    chk(spi_mode_o == 1'b0, "R2", "mode with pin low from reset", spi_mode_o, 0);
    // R10 valid frame while still in two-wire mode
    byte_out(8'h98); byte_out(8'h05); byte_out(8'hAA);
    repeat (8) @(negedge clk);
    chk(seen == 0, "R10", "writes outside SPI mode", seen, 0);
    cclk_i = 1'b0;
    cs_i = 1'b1;
    repeat (10) @(negedge clk);
    chk(spi_mode_o == 1'b0, "R2", "mode after rising pin", spi_mode_o, 0);
    cs_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(spi_mode_o == 1'b1, "R2", "mode after first fall", spi_mode_o, 1);
    cs_i = 1'b1;
    repeat (10) @(negedge clk);

    // R8 no increment: same address
    fb[0] = 8'h98; fb[1] = 8'h05; fb[2] = 8'hA1; fb[3] = 8'hB2;
    run_frame(4, 0);
    // R8 increment with wrap 7E,7F,00
    fb[0] = 8'h98; fb[1] = 8'hFE; fb[2] = 8'h11; fb[3] = 8'h22; fb[4] = 8'h33;
    run_frame(5, 0);
    // R5 wrong chip address
    fb[0] = 8'h99; fb[1] = 8'h01; fb[2] = 8'h44; fb[3] = 8'h55;
    run_frame(4, 0);
    chk(seen == exp_wr, "R5", "writes after bad chip byte", seen, exp_wr);
    // R9 truncated data byte
    fb[0] = 8'h98; fb[1] = 8'h83; fb[2] = 8'h66;
    run_frame(3, 5);
    chk(seen == exp_wr, "R9", "writes after truncated byte", seen, exp_wr);
    // R4 serial clock with chip select high is ignored
    for (int k = 0; k < 16; k++) bit_out(logic'($urandom % 2));
    @(negedge clk) cclk_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(seen == exp_wr, "R4", "writes from clocks with cs high", seen, exp_wr);
    // R4 MSB-first ordering with an asymmetric byte
    fb[0] = 8'h98; fb[1] = 8'h10; fb[2] = 8'h5A; fb[3] = 8'h01;
    run_frame(4, 0);

    for (int f = 0; f < 40; f++) begin
      int n, part;
      n = $urandom % 7;
      part = $urandom % 8;
      fb[0] = ($urandom % 5 == 0) ? 8'($urandom) : 8'h98;
      fb[1] = 8'($urandom);
      if (f % 8 == 0) fb[1] = {1'b1, 7'h7D};
      for (int i = 2; i < 16; i++) fb[i] = 8'($urandom);
      run_frame(n, part);
    end

    chk(spi_mode_o == 1'b1, "R3", "mode stays selected", spi_mode_o, 1);
    chk(seen == exp_wr, "R7", "total write count", seen, exp_wr);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule